// File: doc/BRIEF.md
# Register-Programmed SPI Host Controller

This block is a serial peripheral interface host that software drives through three 16-bit registers on a simple byte-addressed register bus. A write to the data register sends one word, either 8 or 16 bits, MSB first on the serial output. The word coming back on the serial input is captured at the same time. The serial clock comes from the system clock through a 7-bit divider. Two control bits select the clock idle level and the clock edge used for sampling, so all four SPI modes are available. Only one word is in flight at a time. There is no queue.

Software polls the status register or waits on the interrupt. The interrupt has two sources, each with its own enable: "receive word waiting" and "ready for the next write". Chip selects are not part of this block. Clearing the enable bit returns the controller to idle. Software does this after the last word, and also to abandon a word that never completes.

Top module: `spi_host`

## Requirements
- R1: After reset the control register reads 0x0000, the status register reads 0x0000, `sckOut` is low and `irq` is low.
- R2: The register offsets are data 0x0, control 0x2 and status 0x4. The control bits are: bit 0 enable, bit 2 wide (16-bit words when set, 8-bit words when clear), bit 5 receive interrupt enable, bit 6 ready interrupt enable, bit 7 clock idle level (CPOL), bit 8 late sampling (CPHA), bits 15:9 divider N. Bits 1, 3 and 4 always read 0.
- R3: A data write while enabled and idle starts a word. Status bit 0 (busy) reads 1 from the next cycle onward, for exactly 2·W·(N+1) cycles, where W is 8 or 16.
- R4: While idle, `sckOut` equals the CPOL bit. A word produces exactly 2·W clock transitions, each half period lasting N+1 system cycles, and the clock ends at the idle level.
- R5: `mosiOut` carries the written word MSB first. In an 8-bit word, bits 7:0 are sent. With CPHA clear, each bit is valid before the leading clock edge. With CPHA set, each bit changes on a leading edge.
- R6: `misoIn` is sampled on leading edges when CPHA is clear and on trailing edges when CPHA is set, MSB first. The word collected this way is what the data register returns, with bits 15:8 reading 0 for 8-bit words.
- R7: Status bit 1 (receive full) sets in the same cycle that busy falls. A read of the data register clears it.
- R8: `irq` is high exactly when (receive full and bit 5) or (not busy and bit 6).
- R9: A data write is ignored while the enable bit is clear or while a word is in flight. No clock transitions follow, and the word in flight is not changed.
- R10: A control write that clears the enable bit ends a word in flight at once. Busy reads 0 from the next cycle, `sckOut` returns to idle, and receive full is not set. After this, a newly enabled word runs normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | ADDR_W | Byte offset of the register being accessed |
| regWrEn | input | 1 | Write strobe for the addressed register |
| regWrData | input | 16 | Write data |
| regRdEn | input | 1 | Read strobe; a read of the data register clears receive full |
| regRdData | output | 16 | Read data of the addressed register (combinational) |
| sckOut | output | 1 | Serial clock |
| mosiOut | output | 1 | Serial data out |
| misoIn | input | 1 | Serial data in |
| irq | output | 1 | Level interrupt |

## Verification
On every cycle, the assertions check the following:
- a launch raises busy;
- a cleared enable bit forces the controller idle;
- the serial clock sits at its idle level whenever no word is in flight;
- the clock edge counter stays inside the word length;
- completion sets receive full;
- an 8-bit completion leaves the upper byte at zero.

Three things only the bench scenarios can show:
- busy lasts exactly 2·W·(N+1) cycles;
- a bench slave reacting to real clock edges exchanges the exact words in all four modes and both widths;
- writes while disabled or busy leave the transfer unchanged, and the interrupt follows its two enable bits.

// File: rtl/spih_pkg.sv
package spih_pkg;

  localparam int REG_W    = 16;
  localparam int DIV_W    = 7;
  localparam int MAX_BITS = 16;
  localparam int HALF_W   = MAX_BITS / 2;
  localparam int EDGE_W   = $clog2(2 * MAX_BITS + 1);

  // register byte offsets
  localparam int OFS_DATA = 0;
  localparam int OFS_CTRL = 2;
  localparam int OFS_STAT = 4;

  // control bit positions
  localparam int B_EN     = 0;
  localparam int B_WIDE   = 2;
  localparam int B_RXIE   = 5;
  localparam int B_TXIE   = 6;
  localparam int B_CPOL   = 7;
  localparam int B_CPHA   = 8;
  localparam int B_DIV_LO = 9;

  localparam logic [REG_W-1:0] CTRL_MASK = 16'hFFE5;

  typedef struct packed {
    logic launch;
    logic abort;
  } spih_strobe_t;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             cpha;
    logic             cpol;
    logic             wide;
  } spih_cfg_t;

endpackage

// File: rtl/spih_datapath.sv
module spih_datapath
  import spih_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  spih_strobe_t     stb,
  input  spih_cfg_t        cfg,
  input  logic [REG_W-1:0] txWord,
  input  logic             miso,
  output logic             active,
  output logic             done,
  output logic [REG_W-1:0] rxWord,
  output logic             sck,
  output logic             mosi
);

  logic [DIV_W-1:0]  halfCnt;
  logic [EDGE_W-1:0] edgeCnt;
  logic [EDGE_W-1:0] edgeNum;
  logic [EDGE_W-1:0] lastNum;
  logic              phase;
  logic [REG_W-1:0]  txSh;
  logic [REG_W-1:0]  rxSh;
  logic [REG_W-1:0]  rxNext;
  logic              tick;
  logic              leading;
  logic              sampleNow;
  logic              shiftNow;
  logic              firstLead;
  logic              lastEdge;

  assign lastNum   = cfg.wide ? EDGE_W'(2 * MAX_BITS) : EDGE_W'(MAX_BITS);
  assign edgeNum   = edgeCnt + 1'b1;
  assign tick      = active && (halfCnt == cfg.div);
  assign leading   = edgeNum[0];
  assign lastEdge  = (edgeNum == lastNum);
  assign sampleNow = tick && (leading ^ cfg.cpha);
  assign firstLead = cfg.cpha && (edgeNum == EDGE_W'(1));
  assign shiftNow  = tick && !(leading ^ cfg.cpha) && !firstLead;
  assign rxNext    = {rxSh[REG_W-2:0], miso};
  assign done      = tick && lastEdge && !stb.abort;
  assign rxWord    = sampleNow ? rxNext : rxSh;
  assign sck       = phase ^ cfg.cpol;
  assign mosi      = txSh[REG_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      halfCnt <= '0;
      edgeCnt <= '0;
      phase   <= 1'b0;
      txSh    <= '0;
      rxSh    <= '0;
    end else if (stb.abort) begin
      active  <= 1'b0;
      halfCnt <= '0;
      edgeCnt <= '0;
      phase   <= 1'b0;
    end else if (stb.launch && !active) begin
      active  <= 1'b1;
      halfCnt <= '0;
      edgeCnt <= '0;
      phase   <= 1'b0;
      txSh    <= cfg.wide ? txWord : {txWord[HALF_W-1:0], {HALF_W{1'b0}}};
      rxSh    <= '0;
    end else if (active) begin
      if (tick) begin
        halfCnt <= '0;
        phase   <= ~phase;
        if (sampleNow) rxSh <= rxNext;
        if (shiftNow)  txSh <= {txSh[REG_W-2:0], 1'b0};
        if (lastEdge) begin
          active  <= 1'b0;
          edgeCnt <= '0;
        end else begin
          edgeCnt <= edgeNum;
        end
      end else begin
        halfCnt <= halfCnt + 1'b1;
      end
    end
  end

  a_r4_idle_sck_level: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> (sck == cfg.cpol));

  a_r4_edge_bound: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (edgeCnt < lastNum));

  a_r3_done_ends_word: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !active);

endmodule

// File: rtl/spih_ctrl.sv
module spih_ctrl
  import spih_pkg::*;
#(
  parameter int ADDR_W = 3
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  input  logic              regRdEn,
  output logic [REG_W-1:0]  regRdData,
  input  logic              active,
  input  logic              done,
  input  logic [REG_W-1:0]  rxWord,
  output spih_strobe_t      stb,
  output spih_cfg_t         cfg,
  output logic              irq
);

  logic [REG_W-1:0] ctrlReg;
  logic [REG_W-1:0] rxBuf;
  logic             rxFull;
  logic             selData;
  logic             selCtrl;
  logic             selStat;
  logic             wrData;
  logic             wrCtrl;
  logic             rdData;

  assign selData = (regAddr == ADDR_W'(OFS_DATA));
  assign selCtrl = (regAddr == ADDR_W'(OFS_CTRL));
  assign selStat = (regAddr == ADDR_W'(OFS_STAT));
  assign wrData  = regWrEn && selData;
  assign wrCtrl  = regWrEn && selCtrl;
  assign rdData  = regRdEn && selData;

  assign cfg.div  = ctrlReg[REG_W-1:B_DIV_LO];
  assign cfg.cpha = ctrlReg[B_CPHA];
  assign cfg.cpol = ctrlReg[B_CPOL];
  assign cfg.wide = ctrlReg[B_WIDE];

  assign stb.launch = wrData && ctrlReg[B_EN] && !active;
  assign stb.abort  = !ctrlReg[B_EN] || (wrCtrl && !regWrData[B_EN]);

  assign irq = (rxFull && ctrlReg[B_RXIE]) || (!active && ctrlReg[B_TXIE]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
    end else if (wrCtrl) begin
      ctrlReg <= regWrData & CTRL_MASK;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxBuf  <= '0;
      rxFull <= 1'b0;
    end else if (done) begin
      rxBuf  <= cfg.wide ? rxWord : {{HALF_W{1'b0}}, rxWord[HALF_W-1:0]};
      rxFull <= 1'b1;
    end else if (rdData) begin
      rxFull <= 1'b0;
    end
  end

  always_comb begin
    regRdData = '0;
    if (selData)      regRdData = rxBuf;
    else if (selCtrl) regRdData = ctrlReg;
    else if (selStat) regRdData = {{(REG_W-2){1'b0}}, rxFull, active};
  end

  a_r3_launch_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
    stb.launch |=> active);

  a_r9_disabled_stays_idle: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlReg[B_EN] |=> !active);

  a_r10_disable_write_aborts: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && !regWrData[B_EN]) |=> (!active && !rxFull || !active));

  a_r7_done_sets_full: assert property (@(posedge clk) disable iff (!rstN)
    done |=> rxFull);

  a_r7_read_clears_full: assert property (@(posedge clk) disable iff (!rstN)
    (rdData && !done) |=> !rxFull);

  a_r6_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (done && !cfg.wide) |=> (rxBuf[REG_W-1:HALF_W] == '0));

endmodule

// File: rtl/spi_host.sv
module spi_host
  import spih_pkg::*;
#(
  parameter int ADDR_W = 3
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [15:0]       regWrData,
  input  logic              regRdEn,
  output logic [15:0]       regRdData,
  output logic              sckOut,
  output logic              mosiOut,
  input  logic              misoIn,
  output logic              irq
);

  spih_strobe_t     stb;
  spih_cfg_t        cfg;
  logic             active;
  logic             done;
  logic [REG_W-1:0] rxWord;

  spih_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdEn   (regRdEn),
    .regRdData (regRdData),
    .active    (active),
    .done      (done),
    .rxWord    (rxWord),
    .stb       (stb),
    .cfg       (cfg),
    .irq       (irq)
  );

  spih_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .cfg    (cfg),
    .txWord (regWrData),
    .miso   (misoIn),
    .active (active),
    .done   (done),
    .rxWord (rxWord),
    .sck    (sckOut),
    .mosi   (mosiOut)
  );

endmodule

// File: tb/spi_host_tb.sv
module spi_host_tb;

  localparam int A_DATA = 0;
  localparam int A_CTRL = 2;
  localparam int A_STAT = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic        regRdEn = 1'b0;
  logic [15:0] regRdData;
  logic        sckOut;
  logic        mosiOut;
  logic        misoIn;
  logic        irq;

  int checks = 0;
  int failures = 0;

  // bench slave state
  logic [15:0] slvTx = '0;
  logic [15:0] slvRx = '0;
  int          slvIdx = -1;
  bit          armed = 1'b0;
  bit          bCpol = 1'b0;
  bit          bCpha = 1'b0;
  int          edges = 0;

  always #4 clk = ~clk;

  spi_host u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
    .sckOut(sckOut), .mosiOut(mosiOut), .misoIn(misoIn), .irq(irq)
  );

  assign misoIn = (slvIdx >= 0 && slvIdx < 16) ? slvTx[slvIdx[3:0]] : 1'b0;

  always @(sckOut) begin
    if (armed) begin
      edges++;
      if (sckOut != bCpol) begin
        if (!bCpha) slvRx = {slvRx[14:0], mosiOut};
        else        slvIdx--;
      end else begin
        if (!bCpha) slvIdx--;
        else        slvRx = {slvRx[14:0], mosiOut};
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(int addr, logic [15:0] d);
    @(negedge clk);
    regAddr = 3'(addr); regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(int addr, bit clr, output logic [15:0] d);
    @(negedge clk);
    regAddr = 3'(addr); regRdEn = clr;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  function automatic logic [15:0] mkCtrl(int m, bit wide, int n, bit en, bit rxie, bit txie);
    return (16'(n) << 9) | (16'(m[0]) << 8) | (16'(m[1]) << 7) |
           (16'(txie) << 6) | (16'(rxie) << 5) | (16'(wide) << 2) | 16'(en);
  endfunction

  task automatic prepSlave(int m, bit wide, logic [15:0] sw);
    int w;
    w = wide ? 16 : 8;
    bCpol = m[1]; bCpha = m[0];
    slvTx = sw; slvRx = '0; edges = 0;
    slvIdx = bCpha ? w : w - 1;
    armed = 1'b1;
  endtask

  task automatic waitIdle(output int cnt);
    cnt = 0;
    regAddr = 3'(A_STAT);
    #1;
    while (regRdData[0]) begin
      cnt++;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic doXfer(int m, bit wide, int n, logic [15:0] tx, logic [15:0] sw, bit doRead);
    int w;
    int cnt;
    logic [15:0] d;
    logic [15:0] expRx;
    logic [15:0] expSlv;
    w = wide ? 16 : 8;
    wr(A_CTRL, mkCtrl(m, wide, n, 1'b1, 1'b0, 1'b0));
    #1 check(sckOut == m[1], "R4 idle level before word", int'(sckOut), m[1]);
    prepSlave(m, wide, sw);
    wr(A_DATA, tx);
    waitIdle(cnt);
    armed = 1'b0;
    check(cnt == 2 * w * (n + 1), "R3 busy length", cnt, 2 * w * (n + 1));
    check(edges == 2 * w, "R4 clock transitions", edges, 2 * w);
    check(sckOut == m[1], "R4 idle level after word", int'(sckOut), m[1]);
    expSlv = wide ? tx : {8'h00, tx[7:0]};
    check(slvRx == expSlv, "R5 word seen by slave", int'(slvRx), int'(expSlv));
    rd(A_STAT, 1'b0, d);
    check(d == 16'h0002, "R7 receive full after word", int'(d), 2);
    if (doRead) begin
      expRx = wide ? sw : {8'h00, sw[7:0]};
      rd(A_DATA, 1'b1, d);
      check(d == expRx, "R6 received word", int'(d), int'(expRx));
      rd(A_STAT, 1'b0, d);
      check(d == 16'h0000, "R7 read clears receive full", int'(d), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int cnt;
    int e0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(A_CTRL, 1'b0, d);
    check(d == 16'h0000, "R1 control after reset", int'(d), 0);
    rd(A_STAT, 1'b0, d);
    check(d == 16'h0000, "R1 status after reset", int'(d), 0);
    check(sckOut == 1'b0, "R1 sck after reset", int'(sckOut), 0);
    check(irq == 1'b0, "R1 irq after reset", int'(irq), 0);

    // R2 register map and reserved bits
    wr(A_CTRL, 16'hFFFF);
    rd(A_CTRL, 1'b0, d);
    check(d == 16'hFFE5, "R2 control readback", int'(d), 16'hFFE5);
    wr(A_CTRL, 16'h0000);
    rd(A_CTRL, 1'b0, d);
    check(d == 16'h0000, "R2 control cleared", int'(d), 0);

    // sweep: all modes, both widths, several dividers (R3..R7)
    for (int m = 0; m < 4; m++) begin
      for (int wi = 0; wi < 2; wi++) begin
        for (int ni = 0; ni < 3; ni++) begin
          int n;
          logic [15:0] tx;
          logic [15:0] sw;
          n  = (ni == 0) ? 1 : (ni == 1) ? 2 : 6;
          tx = 16'hA5C3 ^ 16'(((m * 6 + wi * 3 + ni) * 16'h1357));
          sw = 16'h3C96 + 16'(((m * 6 + wi * 3 + ni) * 16'h0F1F));
          doXfer(m, wi[0], n, tx, sw, 1'b1);
        end
      end
    end
    // largest divider
    doXfer(0, 1'b1, 127, 16'h8001, 16'h7FFE, 1'b1);

    // R8 interrupt sources
    doXfer(0, 1'b0, 1, 16'h00B4, 16'h004B, 1'b0);
    wr(A_CTRL, mkCtrl(0, 1'b0, 1, 1'b1, 1'b1, 1'b0));
    #1 check(irq == 1'b1, "R8 irq from receive full", int'(irq), 1);
    rd(A_DATA, 1'b1, d);
    #1 check(irq == 1'b0, "R8 irq drops after read", int'(irq), 0);
    wr(A_CTRL, mkCtrl(0, 1'b0, 1, 1'b1, 1'b0, 1'b1));
    #1 check(irq == 1'b1, "R8 irq from ready while idle", int'(irq), 1);
    prepSlave(0, 1'b0, 16'h0011);
    wr(A_DATA, 16'h0022);
    #1 check(irq == 1'b0, "R8 no ready irq while busy", int'(irq), 0);
    waitIdle(cnt);
    armed = 1'b0;
    check(irq == 1'b1, "R8 ready irq after word", int'(irq), 1);
    rd(A_DATA, 1'b1, d);
    check(d == 16'h0011, "R6 word under irq test", int'(d), 16'h0011);

    // R9 write while disabled
    wr(A_CTRL, mkCtrl(1, 1'b1, 1, 1'b0, 1'b0, 1'b0));
    prepSlave(1, 1'b1, 16'hFFFF);
    wr(A_DATA, 16'h1234);
    repeat (40) @(negedge clk);
    armed = 1'b0;
    rd(A_STAT, 1'b0, d);
    check(d == 16'h0000, "R9 disabled write starts nothing", int'(d), 0);
    check(edges == 0, "R9 no clock while disabled", edges, 0);

    // R9 write while busy
    wr(A_CTRL, mkCtrl(1, 1'b0, 2, 1'b1, 1'b0, 1'b0));
    prepSlave(1, 1'b0, 16'h0096);
    wr(A_DATA, 16'h005A);
    repeat (5) @(negedge clk);
    wr(A_DATA, 16'h00C3);
    waitIdle(cnt);
    armed = 1'b0;
    check(slvRx[7:0] == 8'h5A, "R9 word in flight unchanged", int'(slvRx[7:0]), 8'h5A);
    check(edges == 16, "R9 no extra clock after busy write", edges, 16);
    rd(A_DATA, 1'b1, d);
    check(d == 16'h0096, "R9 received word after busy write", int'(d), 16'h0096);
    repeat (40) @(negedge clk);
    rd(A_STAT, 1'b0, d);
    check(d == 16'h0000, "R9 no second word launched", int'(d), 0);

    // R10 abort mid-word
    wr(A_CTRL, mkCtrl(3, 1'b1, 3, 1'b1, 1'b0, 1'b0));
    prepSlave(3, 1'b1, 16'hABCD);
    wr(A_DATA, 16'h4321);
    repeat (20) @(negedge clk);
    wr(A_CTRL, mkCtrl(3, 1'b1, 3, 1'b0, 1'b0, 1'b0));
    #1 check(sckOut == 1'b1, "R10 sck idle after abort", int'(sckOut), 1);
    e0 = edges;
    rd(A_STAT, 1'b0, d);
    check(d == 16'h0000, "R10 busy and full clear after abort", int'(d), 0);
    repeat (40) @(negedge clk);
    check(edges == e0, "R10 no clock after abort", edges, e0);
    armed = 1'b0;
    doXfer(3, 1'b1, 3, 16'h4321, 16'hABCD, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule